// File: doc/BRIEF.md
# Serial Display Link Start-Up Sequencer

This controller lives in the pixel clock domain and walks a current-mode serial display link from a powered-down state to streaming. It watches an active-low sleep input, a pixel-clock-present flag and a bias-ready strobe. It emits three things:
- a two-bit drive-state code for the clock line and for each data lane,
- a link phase indicator,
- a stream-enable output that lets the serialization data path start sending.

A start-up opens with a bias settling interval. The clock line then carries a fixed pulse train: Low, High, Low again. A hold-off interval follows, giving the transmit PLL time to lock, and then the link goes active. The data lanes stay undriven until the second Low pulse.

A single shared down-counter times every interval. It is reloaded with the interval length minus one each time a state is entered. The state advances on the cycle the counter reads zero, so each interval lasts exactly its parameterized number of cycles. Dropping the sleep input or losing the pixel clock sends the block back to the off phase from any state. The analog drivers, the PLL and the data path lie outside this block and consume its outputs.

Top module: `lnk_wake_seq`

## Requirements
- R1: While the block is off or in reset, every drive code is 00 (off), `phase` is 00 (off) and `stream_en` is 0.
- R2: A start-up begins when `sleep_n` and `pclk_ok` are both high, in either order of arrival. The first clock edge that sees both high enters the bias interval.
- R3: The bias interval keeps all lines at 00 and `phase` at 00. It ends after the edge where `bias_rdy` is seen high, or after BIAS_CYC cycles, whichever comes first. `bias_rdy` has no effect in any other state.
- R4: The first Low pulse drives the clock line with code 01 (Low, higher current) for exactly LO1_CYC cycles. The data lanes stay at 00 and `phase` is 01 (link-up).
- R5: The High pulse then drives the clock line with code 10 (High, lower current) for exactly HI_CYC cycles. The data lanes stay at 00 and `phase` is 01.
- R6: The second Low pulse drives the clock line with code 01 for exactly LO2_CYC cycles. Every data lane is driven at 01 and `phase` is 01.
- R7: The PLL hold-off lasts exactly HOLD_CYC cycles. The clock line and every data lane hold code 01 and `phase` stays 01.
- R8: After the hold-off, the clock line and every data lane carry code 11 (running), `phase` is 10 (active) and `stream_en` is 1. This holds until an abort.
- R9: If `sleep_n` or `pclk_ok` is low at a clock edge, the outputs show the off state of R1 from the next cycle, whatever the state was.
- R10: After an abort, a new start-up runs the whole sequence again from the bias interval, with every interval at its full length.
- R11: States advance only in the fixed order bias, Low, High, Low, hold-off, active. The only other transition is a return to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Power-down control, low = power down |
| pclk_ok | input | 1 | High while the pixel clock is present |
| bias_rdy | input | 1 | Bias block settled; ends the bias interval early |
| clk_drv | output | 2 | Clock line drive code: 00 off, 01 Low, 10 High, 11 running |
| dat_drv | output | 2*N_LANE | Data lane drive codes; lane i at bits [2i+1:2i], same encoding as clk_drv |
| phase | output | 2 | Link phase: 00 off, 01 link-up, 10 active |
| stream_en | output | 1 | Data path may stream |

## Verification
Two kinds of event can land on the same clock edge. An abort can coincide with the counter reaching zero, which would otherwise advance the state. A `bias_rdy` strobe can also arrive on the last counted bias cycle. The bench reproduces both collisions by sweeping the abort edge across every cycle of a shortened sequence, alternating `sleep_n` and `pclk_ok` as the cause, and by sweeping the strobe position across and beyond the bias window. For every cycle it computes the expected drive codes arithmetically from the interval lengths. An abort must always win over the state advance, and an early strobe must never lengthen the bias interval past its count.

// File: rtl/lnk_wake_pkg.sv
package lnk_wake_pkg;
  typedef enum logic [2:0] {
    S_OFF  = 3'd0,
    S_BIAS = 3'd1,
    S_LO1  = 3'd2,
    S_HI   = 3'd3,
    S_LO2  = 3'd4,
    S_HOLD = 3'd5,
    S_ACT  = 3'd6
  } seq_st_t;

  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_LO  = 2'b01,
    DRV_HI  = 2'b10,
    DRV_RUN = 2'b11
  } drv_t;

  typedef enum logic [1:0] {
    PH_OFF = 2'b00,
    PH_UP  = 2'b01,
    PH_ACT = 2'b10
  } phase_t;
endpackage

// File: rtl/lnk_wake_timer.sv
module lnk_wake_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lnk_wake_drv.sv
module lnk_wake_drv
  import lnk_wake_pkg::*;
#(
  parameter int N_LANE = 3
) (
  input  seq_st_t             st,
  output logic [1:0]          clk_drv,
  output logic [2*N_LANE-1:0] dat_drv,
  output logic [1:0]          phase,
  output logic                stream_en
);
  drv_t   clk_code, lane_code;
  phase_t ph;

  always_comb begin
    clk_code  = DRV_OFF;
    lane_code = DRV_OFF;
    ph        = PH_OFF;
    unique case (st)
      S_LO1:  begin clk_code = DRV_LO; ph = PH_UP; end
      S_HI:   begin clk_code = DRV_HI; ph = PH_UP; end
      S_LO2, S_HOLD: begin
        clk_code  = DRV_LO;
        lane_code = DRV_LO;
        ph        = PH_UP;
      end
      S_ACT:  begin
        clk_code  = DRV_RUN;
        lane_code = DRV_RUN;
        ph        = PH_ACT;
      end
      default: ;
    endcase
  end

  assign clk_drv   = clk_code;
  assign phase     = ph;
  assign stream_en = (st == S_ACT);

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    assign dat_drv[2*i +: 2] = lane_code;
  end
endmodule

// File: rtl/lnk_wake_seq.sv
module lnk_wake_seq
  import lnk_wake_pkg::*;
#(
  parameter int N_LANE   = 3,
  parameter int BIAS_CYC = 64,
  parameter int LO1_CYC  = 200,
  parameter int HI_CYC   = 20,
  parameter int LO2_CYC  = 8,
  parameter int HOLD_CYC = 600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_n,
  input  logic                pclk_ok,
  input  logic                bias_rdy,
  output logic [1:0]          clk_drv,
  output logic [2*N_LANE-1:0] dat_drv,
  output logic [1:0]          phase,
  output logic                stream_en
);
  localparam int M1   = (BIAS_CYC > LO1_CYC) ? BIAS_CYC : LO1_CYC;
  localparam int M2   = (HI_CYC > LO2_CYC) ? HI_CYC : LO2_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > HOLD_CYC) ? M3 : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_t       st, nxt;
  logic          ld, tmr_zero, link_ok;
  logic [CW-1:0] ldv;

  assign link_ok = sleep_n & pclk_ok;

  always_comb begin
    nxt = st;
    ld  = 1'b0;
    ldv = '0;
    if (!link_ok) begin
      nxt = S_OFF;
      ld  = 1'b1;
    end else begin
      unique case (st)
        S_OFF:  begin nxt = S_BIAS; ld = 1'b1; ldv = CW'(BIAS_CYC - 1); end
        S_BIAS: if (bias_rdy || tmr_zero) begin
                  nxt = S_LO1; ld = 1'b1; ldv = CW'(LO1_CYC - 1);
                end
        S_LO1:  if (tmr_zero) begin nxt = S_HI;   ld = 1'b1; ldv = CW'(HI_CYC - 1);   end
        S_HI:   if (tmr_zero) begin nxt = S_LO2;  ld = 1'b1; ldv = CW'(LO2_CYC - 1);  end
        S_LO2:  if (tmr_zero) begin nxt = S_HOLD; ld = 1'b1; ldv = CW'(HOLD_CYC - 1); end
        S_HOLD: if (tmr_zero) nxt = S_ACT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_OFF;
    else        st <= nxt;
  end

  lnk_wake_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ldv),
    .zero     (tmr_zero)
  );

  lnk_wake_drv #(.N_LANE(N_LANE)) u_drv (
    .st        (st),
    .clk_drv   (clk_drv),
    .dat_drv   (dat_drv),
    .phase     (phase),
    .stream_en (stream_en)
  );

  // R9: an abort at an edge forces the off state in the next cycle
  a_r9_abort_off: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> (st == S_OFF && clk_drv == 2'b00 && stream_en == 1'b0));

  // R4: the first Low pulse holds while the timer is still counting
  a_r4_lo1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LO1 && !tmr_zero && link_ok) |=> st == S_LO1);

  // R11: any change other than a return to off is a single step forward
  a_r11_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st) && st != S_OFF) |-> (3'(st) == 3'($past(st)) + 3'd1));

  // R5: data lanes stay undriven before the second Low pulse
  a_r5_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LO1 || st == S_HI || st == S_BIAS) |-> dat_drv == '0);

  // R8: streaming only ever opens straight out of the hold-off
  a_r8_stream_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_en) |-> $past(st) == S_HOLD);

  // R3: the bias interval never outlasts a seen ready strobe
  a_r3_bias_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIAS && bias_rdy && link_ok) |=> st == S_LO1);
endmodule

// File: tb/tb_lnk_wake_seq.sv
`timescale 1ns/1ps
module tb_lnk_wake_seq;
  localparam int NL = 2, BC = 5, L1 = 6, HC = 3, L2 = 2, HD = 4;
  localparam int W  = 2 + 2*NL + 2 + 1;

  logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b0, pclk_ok = 1'b0, bias_rdy = 1'b0;
  logic [1:0] clk_drv, phase;
  logic [2*NL-1:0] dat_drv;
  logic stream_en;
  int checks = 0, failures = 0;
  bit done = 0, prev_abort = 0;

  always #5 clk = ~clk;

  lnk_wake_seq #(.N_LANE(NL), .BIAS_CYC(BC), .LO1_CYC(L1), .HI_CYC(HC),
                 .LO2_CYC(L2), .HOLD_CYC(HD)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .pclk_ok(pclk_ok),
    .bias_rdy(bias_rdy), .clk_drv(clk_drv), .dat_drv(dat_drv),
    .phase(phase), .stream_en(stream_en));

  // stage: 0 off, 1 bias, 2 low1, 3 high, 4 low2, 5 hold, 6 active
  function automatic int stage_of(int k, int b);
    if (k < b) return 1;
    if (k < b + L1) return 2;
    if (k < b + L1 + HC) return 3;
    if (k < b + L1 + HC + L2) return 4;
    if (k < b + L1 + HC + L2 + HD) return 5;
    return 6;
  endfunction

  function automatic logic [W-1:0] exp_vec(int s);
    logic [1:0] c, d, p;
    logic [2*NL-1:0] dd;
    c = 2'b00; d = 2'b00; p = 2'b00;
    case (s)
      2: begin c = 2'b01; p = 2'b01; end
      3: begin c = 2'b10; p = 2'b01; end
      4, 5: begin c = 2'b01; d = 2'b01; p = 2'b01; end
      6: begin c = 2'b11; d = 2'b11; p = 2'b10; end
      default: ;
    endcase
    dd = {NL{d}};
    return {c, dd, p, (s == 6)};
  endfunction

  function automatic string tag_of(int s);
    case (s)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] e);
    logic [W-1:0] a;
    a = {clk_drv, dat_drv, phase, stream_en};
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, a, e);
    end
  endtask

  task automatic go_off();
    sleep_n = 1'b0; pclk_ok = 1'b1; bias_rdy = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R1", '0);
  endtask

  // bias_at: cycle of the bias window where bias_rdy rises (held after), -1 none
  // abort_at: cycle where sleep_n (even) or pclk_ok (odd) drops, -1 none
  // order 1: pclk_ok arrives after sleep_n
  task automatic run_seq(int bias_at, int abort_at, int order);
    int b, total;
    string tg;
    go_off();
    if (order == 1) begin
      pclk_ok = 1'b0; sleep_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk("R2", '0);
      pclk_ok = 1'b1;
    end else begin
      sleep_n = 1'b1;
    end
    b = (bias_at >= 0 && bias_at < BC) ? bias_at + 1 : BC;
    total = b + L1 + HC + L2 + HD + 3;
    for (int k = 0; k < total; k++) begin
      @(posedge clk); #1;
      if (abort_at >= 0 && k > abort_at) begin
        chk("R9", '0);
      end else begin
        tg = prev_abort ? {"R10/", tag_of(stage_of(k, b))} : tag_of(stage_of(k, b));
        chk(tg, exp_vec(stage_of(k, b)));
      end
      if (k == bias_at) bias_rdy = 1'b1;
      if (k == abort_at) begin
        if (abort_at % 2 == 0) sleep_n = 1'b0;
        else pclk_ok = 1'b0;
      end
    end
    prev_abort = (abort_at >= 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", '0);
    rst_n = 1'b1;
    @(posedge clk); #1 chk("R1", '0);
    // R3: bias_rdy while off has no effect
    bias_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R3", '0);
    bias_rdy = 1'b0;
    // R3: strobe position swept across and past the bias window
    for (int bi = -1; bi <= BC + 2; bi++) run_seq(bi, -1, 0);
    // R2: pixel clock arriving last
    run_seq(-1, -1, 1);
    run_seq(1, -1, 1);
    // R9/R10/R11: abort at every cycle of the sequence, then full restart
    for (int ai = 0; ai <= BC + L1 + HC + L2 + HD + 1; ai++) begin
      run_seq(-1, ai, 0);
      run_seq(2, -1, 0);
    end
    // abort on the same edge as a bias strobe
    run_seq(1, 1, 0);
    run_seq(-1, -1, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule